// File: doc/BRIEF.md
# Dual-Channel Timer Capture/Compare Unit

The block runs a free-running up-counter and hangs two timer channels off it. Each channel either latches the counter when a selected edge arrives on its input pin (capture) or raises an event when the counter reaches a stored value and drives its pin as a result (compare). Every event sets a per-channel flag. The flag and its interrupt enable produce that channel's interrupt line. Software clears the flag with a guarded sequence: a read that sees the flag set, then a write of 0. A new event that arrives before the write cancels the clear, so an event is never lost.

Channel 0 has an extra buffered mode for pulse-width modulation. In this mode its compare value is double-buffered and reloads only when the counter wraps. The pin goes high on the wrap and low on the match. While channel 0 is in buffered mode, channel 1 is switched off: its control register reads as zero and ignores writes, and its pin is released for general-purpose use.

Software reaches the block through a single-cycle byte-wide register bus. Read data is combinational on the address.

Top module: `twin_capcmp`

## Requirements
- R1: After reset the counter is 0. It advances by one every clock and wraps from all-ones to 0. It reads at offset 6 (upper byte) and offset 7 (lower byte); bits above CNT_W read 0.
- R2: In capture mode (control bits 5:4 = 00), edge-select bits 3:2 choose the active pin edge: 01 rising, 10 falling, 11 either, 00 none. An active edge sets the flag on the third rising clock edge after the pin changes. On that same edge it latches the count that stood two cycles after the change into the channel value register.
- R3: In compare mode (bit 4 = 1, bit 5 = 0), the flag sets on the clock edge at which the counter equals the channel value. On that edge the pin toggles (edge-select 01), goes low (10) or goes high (11). With 00 the pin is not driven (output enable 0).
- R4: A flag clears only when a write of 0 to bit 7 follows a read of the control register that returned bit 7 = 1. A write of 0 with no such read leaves the flag set.
- R5: If an event occurs after the arming read and no later than the clock edge of the write of 0, the write leaves the flag set.
- R6: Writing 1 to bit 7 never sets the flag. Reset clears every flag, every control bit and the pin outputs.
- R7: A channel's interrupt output is high exactly while its flag (bit 7) and its interrupt enable (bit 6) are both 1.
- R8: Control layout, bit 7 down to bit 0: flag, interrupt enable, buffered mode, compare mode, edge select (2 bits), toggle-on-wrap, full-duty. Bit 5 exists only in channel 0; in channel 1 it reads 0.
- R9: While channel 0 bit 5 is 1, channel 1's control register (offset 3) reads 0 and ignores writes. Its pin enable and interrupt are held at 0. Clearing bit 5 restores channel 1's earlier settings.
- R10: In buffered mode, writes to channel 0's value take effect only at the next counter wrap. When edge select is not 00, the pin goes high at the wrap and low at the match. With bit 0 set, the pin stays high.
- R11: In plain compare mode with bit 1 set and edge select not 00, the pin also toggles when the counter wraps.
- R12: Offsets 0/1/2 are channel 0's control, value upper byte and value lower byte; offsets 3/4/5 are the same for channel 1. Value bytes read back as written, with bits above CNT_W reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| ch_pin_in | input | 2 | Channel pin inputs (capture) |
| ch_pin_out | output | 2 | Channel pin outputs (compare) |
| ch_pin_oe | output | 2 | Channel pin output enables |
| ch_irq | output | 2 | Per-channel interrupt requests |

## Verification
The functions that collide are the flag-clearing write and a fresh compare event. The bench polls the counter so that, after the arming read, the write of 0 commits on the very clock edge at which the counter matches the stored value. It then expects the flag and the interrupt to stay set. A second case leaves one idle cycle between the read and the write so that the match falls strictly between them, and expects the same result. A final case runs the sequence with no event in between and expects the flag to clear.

// File: rtl/tcc_pkg.sv
// Shared types and register offsets for the dual-channel capture/compare unit.
// Assumes two channels, three bus offsets per channel, counter at the top.
package tcc_pkg;

    localparam int ADDR_W      = 3;
    localparam int NCH         = 2;
    localparam int REGS_PER_CH = 3;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO = 3'd7;

    // Channel configuration, bit 6 down to bit 0 of the control byte.
    typedef struct packed {
        logic       ie;     // interrupt enable
        logic       bufm;   // buffered compare / PWM (channel 0 only)
        logic       cmpm;   // compare mode
        logic [1:0] esel;   // edge / pin action select
        logic       tow;    // toggle on counter wrap
        logic       fulld;  // full duty in buffered mode
    } tcc_cfg_t;

    // Capture edge qualification from the edge-select code.
    function automatic logic edge_match(input logic [1:0] esel,
                                        input logic rise,
                                        input logic fall);
        case (esel)
            2'b01:   return rise;
            2'b10:   return fall;
            2'b11:   return rise | fall;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tcc_counter.sv
// Free-running up-counter shared by both channels.
// Assumes CNT_W is at least 2; wrap is high in the cycle before the roll-over.
module tcc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    // Advance the count every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Flag the last count before roll-over.
    assign wrap = &cnt;

endmodule

// File: rtl/tcc_channel.sv
// One timer channel: configuration, value register, event flag with guarded
// clear, input capture, output compare and (when HAS_BUF) buffered PWM.
// Assumes CNT_W <= 16 and that the bus strobes are single-cycle pulses.
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit HAS_BUF = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic             enable,
    input  logic             pin_in,
    input  logic             ctrl_wr,
    input  logic             ctrl_rd,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [7:0]       wdata,
    output logic [7:0]       ctrl_q,
    output logic [CNT_W-1:0] val_q,
    output logic             irq,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             buf_mode
);

    tcc_cfg_t         cfg;
    tcc_cfg_t         cfg_nxt;
    logic             flag;
    logic             armed;
    logic             sync1;
    logic             sync2;
    logic             prev;
    logic             rise;
    logic             fall;
    logic [CNT_W-1:0] val;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] cmp_ref;
    logic [15:0]      val_w;
    logic             buffered;
    logic             cmp_mode;
    logic             cap_evt;
    logic             cmp_evt;
    logic             evt;
    logic             drive;

    // Two-stage pin synchroniser plus edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign rise = sync2 & ~prev;
    assign fall = ~sync2 & prev;

    // Mode decode and event detection.
    assign buffered = HAS_BUF && cfg.bufm;
    assign cmp_mode = buffered || cfg.cmpm;
    assign cmp_ref  = buffered ? act : val;
    assign cap_evt  = enable && !cmp_mode && edge_match(cfg.esel, rise, fall);
    assign cmp_evt  = enable && cmp_mode && (cnt == cmp_ref);
    assign evt      = cap_evt || cmp_evt;
    assign drive    = cfg.esel != 2'b00;

    // Next configuration from a control write; bit 5 only on the buffered channel.
    always_comb begin
        cfg_nxt = tcc_cfg_t'(wdata[6:0]);
        if (!HAS_BUF) cfg_nxt.bufm = 1'b0;
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg <= '0;
        else if (ctrl_wr) cfg <= cfg_nxt;
    end

    // Event flag: events set it, an armed write of 0 clears it, events win.
    always_ff @(posedge clk) begin
        if (!rst_n)                                flag <= 1'b0;
        else if (evt)                              flag <= 1'b1;
        else if (ctrl_wr && armed && !wdata[7])    flag <= 1'b0;
    end

    // Clear arming: a read that saw the flag set, dropped by any write or event.
    always_ff @(posedge clk) begin
        if (!rst_n)                 armed <= 1'b0;
        else if (evt || ctrl_wr)    armed <= 1'b0;
        else if (ctrl_rd && flag)   armed <= 1'b1;
    end

    assign val_w = 16'(val);

    // Value register: capture has priority over bus byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       val <= '0;
        else if (cap_evt) val <= cnt;
        else if (hi_wr)   val <= CNT_W'({wdata, val_w[7:0]});
        else if (lo_wr)   val <= CNT_W'({val_w[15:8], wdata});
    end

    // Active compare value, reloaded from the buffer at each counter wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                act <= '0;
        else if (buffered && wrap) act <= val;
    end

    // Pin output state for compare and PWM actions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
        end else if (buffered) begin
            if (drive) begin
                if (cfg.fulld)    pin_out <= 1'b1;
                else if (cmp_evt) pin_out <= 1'b0;
                else if (wrap)    pin_out <= 1'b1;
            end
        end else if (cmp_mode && drive) begin
            if (cmp_evt) begin
                case (cfg.esel)
                    2'b01:   pin_out <= ~pin_out;
                    2'b10:   pin_out <= 1'b0;
                    default: pin_out <= 1'b1;
                endcase
            end else if (wrap && cfg.tow) begin
                pin_out <= ~pin_out;
            end
        end
    end

    assign pin_oe   = enable && cmp_mode && drive;
    assign irq      = enable && flag && cfg.ie;
    assign ctrl_q   = {flag, cfg};
    assign val_q    = val;
    assign buf_mode = buffered;

endmodule

// File: rtl/tcc_regbus.sv
// Register bus decode: per-channel write/read strobes and combinational read mux.
// Assumes NCH * REGS_PER_CH + 2 offsets fit in ADDR_W bits.
module tcc_regbus
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [NCH-1:0]            ch_en,
    input  logic [NCH-1:0][7:0]       ctrl,
    input  logic [NCH-1:0][CNT_W-1:0] val,
    input  logic [CNT_W-1:0]          cnt,
    output logic [NCH-1:0]            ctrl_wr,
    output logic [NCH-1:0]            ctrl_rd,
    output logic [NCH-1:0]            hi_wr,
    output logic [NCH-1:0]            lo_wr,
    output logic [7:0]                rdata
);

    logic        wr_hit;
    logic        rd_hit;
    logic [15:0] cnt_w;

    assign wr_hit = bus_sel && bus_wr;
    assign rd_hit = bus_sel && !bus_wr;
    assign cnt_w  = 16'(cnt);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * REGS_PER_CH);
        // Strobes for this channel's three offsets; control gated by enable.
        assign ctrl_wr[i] = wr_hit && (bus_addr == BASE) && ch_en[i];
        assign ctrl_rd[i] = rd_hit && (bus_addr == BASE) && ch_en[i];
        assign hi_wr[i]   = wr_hit && (bus_addr == BASE + 1'b1);
        assign lo_wr[i]   = wr_hit && (bus_addr == BASE + 2'd2);
    end

    // Read data mux, combinational on the address.
    always_comb begin
        logic [15:0] vw;
        rdata = 8'h00;
        for (int i = 0; i < NCH; i++) begin
            vw = 16'(val[i]);
            if (bus_addr == ADDR_W'(i * REGS_PER_CH))
                rdata = ch_en[i] ? ctrl[i] : 8'h00;
            else if (bus_addr == ADDR_W'(i * REGS_PER_CH + 1))
                rdata = vw[15:8];
            else if (bus_addr == ADDR_W'(i * REGS_PER_CH + 2))
                rdata = vw[7:0];
        end
        if (bus_addr == OFF_CNT_HI) rdata = cnt_w[15:8];
        if (bus_addr == OFF_CNT_LO) rdata = cnt_w[7:0];
    end

endmodule

// File: rtl/twin_capcmp.sv
// Top: shared counter, two channels (channel 0 with buffered PWM) and the
// register bus. Buffered mode on any channel disables channel 1.
// Assumes a synchronous active-low reset and CNT_W between 2 and 16.
module twin_capcmp
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [NCH-1:0]    ch_pin_in,
    output logic [NCH-1:0]    ch_pin_out,
    output logic [NCH-1:0]    ch_pin_oe,
    output logic [NCH-1:0]    ch_irq
);

    logic [CNT_W-1:0]          cnt;
    logic                      wrap;
    logic [NCH-1:0]            ch_en;
    logic [NCH-1:0]            ch_buf;
    logic                      buf_any;
    logic [NCH-1:0][7:0]       ch_ctrl;
    logic [NCH-1:0][CNT_W-1:0] ch_val;
    logic [NCH-1:0]            s_ctrl_wr;
    logic [NCH-1:0]            s_ctrl_rd;
    logic [NCH-1:0]            s_hi_wr;
    logic [NCH-1:0]            s_lo_wr;

    tcc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt),
        .wrap (wrap)
    );

    assign buf_any = |ch_buf;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Channel 0 always runs; the others stop while buffered mode is on.
        assign ch_en[i] = (i == 0) ? 1'b1 : !buf_any;

        tcc_channel #(.CNT_W(CNT_W), .HAS_BUF(i == 0)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .wrap    (wrap),
            .enable  (ch_en[i]),
            .pin_in  (ch_pin_in[i]),
            .ctrl_wr (s_ctrl_wr[i]),
            .ctrl_rd (s_ctrl_rd[i]),
            .hi_wr   (s_hi_wr[i]),
            .lo_wr   (s_lo_wr[i]),
            .wdata   (bus_wdata),
            .ctrl_q  (ch_ctrl[i]),
            .val_q   (ch_val[i]),
            .irq     (ch_irq[i]),
            .pin_out (ch_pin_out[i]),
            .pin_oe  (ch_pin_oe[i]),
            .buf_mode(ch_buf[i])
        );
    end

    tcc_regbus #(.CNT_W(CNT_W)) u_bus (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ch_en   (ch_en),
        .ctrl    (ch_ctrl),
        .val     (ch_val),
        .cnt     (cnt),
        .ctrl_wr (s_ctrl_wr),
        .ctrl_rd (s_ctrl_rd),
        .hi_wr   (s_hi_wr),
        .lo_wr   (s_lo_wr),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/tcc_checker.sv
// Property checker for twin_capcmp, attached with bind below.
// Assumes the counter and control bytes are reachable by name in the top.
module tcc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0][7:0]  ctrl,
    input logic             buf_mode,
    input logic [1:0]       pin_oe,
    input logic [1:0]       irq
);

    logic [1:0] age;
    logic       ok;

    // Cycles since reset, saturating, so $past never reaches before reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end
    assign ok = (age == 2'd3);

    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> cnt == CNT_W'($past(cnt) + 1'b1));

    p_clear0_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $fell(ctrl[0][7])) |->
        $past(bus_sel && bus_wr && bus_addr == 3'd0 && !bus_wdata[7]));

    p_clear1_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $fell(ctrl[1][7])) |->
        $past(bus_sel && bus_wr && bus_addr == 3'd3 && !bus_wdata[7]));

    p_irq_rise_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ok && $rose(irq[0])) |-> ctrl[0][6]);

    p_cap_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0][5:4] == 2'b00) |-> !pin_oe[0]);

    p_ch1_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode |-> (!pin_oe[1] && !irq[1]));

    p_ch1_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && bus_addr == 3'd3) |-> bus_rdata == 8'h00);

    p_resv_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[1][5]);

endmodule

bind twin_capcmp tcc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt      (cnt),
    .ctrl     (ch_ctrl),
    .buf_mode (buf_any),
    .pin_oe   (ch_pin_oe),
    .irq      (ch_irq)
);

// File: tb/sim_twin_capcmp.sv
module sim_twin_capcmp;

    localparam int CW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_out;
    logic [1:0] pin_oe;
    logic [1:0] irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    twin_capcmp #(.CNT_W(CW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_pin_in (pin_in),
        .ch_pin_out(pin_out),
        .ch_pin_oe (pin_oe),
        .ch_irq    (irq)
    );

    always #10 clk = ~clk;

    // Capture vectors: {edge select, rising transition, flag expected}.
    localparam logic [3:0] VEC [8] = '{
        4'b01_1_1, 4'b01_0_0, 4'b10_1_0, 4'b10_0_1,
        4'b11_1_1, 4'b11_0_1, 4'b00_1_0, 4'b00_0_0
    };

    task automatic check(input bit good, input string tag, input int act, input int exp);
        n_run++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_sel = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        logic [7:0] c;
        for (int k = 0; k < 600; k++) begin
            peek(3'd7, c);
            if (c == v) return;
            @(negedge clk);
        end
    endtask

    task automatic wait_flag(input logic [2:0] a);
        logic [7:0] c;
        for (int k = 0; k < 600; k++) begin
            peek(a, c);
            if (c[7]) return;
            @(negedge clk);
        end
    endtask

    task automatic clear_flag(input logic [2:0] a);
        logic [7:0] c;
        bus_read(a, c);
        bus_write(a, c & 8'h7F);
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] c;
        logic [7:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        peek(3'd7, d); check(d == 8'd1, "R1 count after reset", d, 1);
        @(negedge clk);
        peek(3'd7, d); check(d == 8'd2, "R1 count step", d, 2);
        peek(3'd6, d); check(d == 8'd0, "R1 upper byte", d, 0);
        peek(3'd0, d); check(d == 8'h00, "R6 ctrl0 reset", d, 0);
        peek(3'd3, d); check(d == 8'h00, "R6 ctrl1 reset", d, 0);
        check(irq == 2'b00 && pin_oe == 2'b00, "R6 outputs reset", {irq, pin_oe}, 0);

        // R2 capture edge table
        foreach (VEC[i]) begin
            pin_in[0] = !VEC[i][1];
            bus_write(3'd0, {4'b0000, VEC[i][3:2], 2'b00});
            repeat (5) @(negedge clk);
            clear_flag(3'd0);
            pin_in[0] = ~pin_in[0];
            repeat (5) @(negedge clk);
            peek(3'd0, d);
            check(d[7] == VEC[i][0], $sformatf("R2 edge vector %0d", i), d[7], VEC[i][0]);
        end

        // R2 captured value
        bus_write(3'd0, 8'h04);
        pin_in[0] = 1'b0;
        repeat (5) @(negedge clk);
        clear_flag(3'd0);
        peek(3'd7, c);
        pin_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        peek(3'd2, d); check(d == 8'(c + 8'd2), "R2 captured count", d, 8'(c + 8'd2));
        peek(3'd1, d); check(d == 8'h00, "R12 value upper byte", d, 0);

        // R3 compare timing and pin actions
        bus_write(3'd0, 8'h00);
        peek(3'd7, c);
        v = 8'(c + 8'd40);
        bus_write(3'd2, v);
        bus_write(3'd0, 8'h14);
        clear_flag(3'd0);
        wait_flag(3'd0);
        peek(3'd7, d); check(d == 8'(v + 8'd1), "R3 flag on match edge", d, 8'(v + 8'd1));
        check(pin_out[0] == 1'b1 && pin_oe[0], "R3 toggle on match", {pin_oe[0], pin_out[0]}, 3);
        bus_write(3'd0, 8'h18); clear_flag(3'd0); wait_flag(3'd0);
        check(pin_out[0] == 1'b0, "R3 clear on match", pin_out[0], 0);
        bus_write(3'd0, 8'h1C); clear_flag(3'd0); wait_flag(3'd0);
        check(pin_out[0] == 1'b1, "R3 set on match", pin_out[0], 1);
        bus_write(3'd0, 8'h10); clear_flag(3'd0); wait_flag(3'd0);
        check(pin_oe[0] == 1'b0, "R3 no drive with select 00", pin_oe[0], 0);

        // R7 / R4 / R6 flag handling (flag set now)
        check(irq[0] == 1'b0, "R7 irq masked by enable", irq[0], 0);
        bus_write(3'd0, 8'h50);
        peek(3'd0, d); check(d[7] == 1'b1, "R4 write 0 without read", d[7], 1);
        check(irq[0] == 1'b1, "R7 irq with flag and enable", irq[0], 1);
        bus_read(3'd0, d);
        bus_write(3'd0, 8'h50);
        peek(3'd0, d); check(d[7] == 1'b0, "R4 armed clear", d[7], 0);
        check(irq[0] == 1'b0, "R7 irq after clear", irq[0], 0);
        bus_write(3'd0, 8'hD0);
        peek(3'd0, d); check(d[7] == 1'b0, "R6 write 1 to flag", d[7], 0);

        // R5 event on the clearing write's edge
        wait_flag(3'd0);
        wait_cnt(8'(v - 8'd1));
        bus_read(3'd0, d);
        bus_write(3'd0, 8'h50);
        peek(3'd0, d); check(d[7] == 1'b1, "R5 event on clearing edge", d[7], 1);
        check(irq[0] == 1'b1, "R5 irq kept", irq[0], 1);
        // R5 event strictly between read and write
        wait_cnt(8'(v - 8'd1));
        bus_read(3'd0, d);
        @(negedge clk);
        bus_write(3'd0, 8'h50);
        peek(3'd0, d); check(d[7] == 1'b1, "R5 event between read and write", d[7], 1);
        clear_flag(3'd0);
        peek(3'd0, d); check(d[7] == 1'b0, "R4 clear with no event", d[7], 0);

        // R8 layout and R12 offsets on channel 1
        bus_write(3'd3, 8'hFF);
        peek(3'd3, d); check((d & 8'h7F) == 8'h5F, "R8 ch1 bit5 reserved", d & 8'h7F, 8'h5F);
        bus_write(3'd3, 8'h5C);
        bus_write(3'd5, 8'hA5);
        peek(3'd5, d); check(d == 8'hA5, "R12 ch1 value lower byte", d, 8'hA5);
        peek(3'd4, d); check(d == 8'h00, "R12 ch1 value upper byte", d, 0);
        check(pin_oe[1] == 1'b1, "R3 ch1 drives in compare", pin_oe[1], 1);

        // R9 buffered mode disables channel 1
        bus_write(3'd0, 8'h20);
        peek(3'd3, d); check(d == 8'h00, "R9 ch1 reads zero", d, 0);
        check(pin_oe[1] == 1'b0 && irq[1] == 1'b0, "R9 ch1 outputs off", {pin_oe[1], irq[1]}, 0);
        bus_write(3'd3, 8'h00);
        bus_write(3'd0, 8'h00);
        peek(3'd3, d); check((d & 8'h7F) == 8'h5C, "R9 ch1 write ignored", d & 8'h7F, 8'h5C);
        check(pin_oe[1] == 1'b1, "R9 ch1 restored", pin_oe[1], 1);
        bus_write(3'd3, 8'h00);

        // R10 buffered PWM
        bus_write(3'd2, 8'h40);
        bus_write(3'd0, 8'h28);
        wait_cnt(8'hF0); wait_cnt(8'h10);
        check(pin_out[0] == 1'b1 && pin_oe[0], "R10 high after wrap", {pin_oe[0], pin_out[0]}, 3);
        wait_cnt(8'h50);
        check(pin_out[0] == 1'b0, "R10 low after match", pin_out[0], 0);
        wait_cnt(8'h10);
        bus_write(3'd2, 8'h80);
        wait_cnt(8'h50);
        check(pin_out[0] == 1'b0, "R10 new value waits for wrap", pin_out[0], 0);
        wait_cnt(8'h10); wait_cnt(8'h50);
        check(pin_out[0] == 1'b1, "R10 new value after wrap", pin_out[0], 1);
        wait_cnt(8'h90);
        check(pin_out[0] == 1'b0, "R10 low at new match", pin_out[0], 0);
        bus_write(3'd0, 8'h29);
        wait_cnt(8'h10); wait_cnt(8'h90);
        check(pin_out[0] == 1'b1, "R10 full duty", pin_out[0], 1);

        // R11 toggle on wrap
        bus_write(3'd0, 8'h1E);
        wait_cnt(8'h10); wait_cnt(8'h90);
        check(pin_out[0] == 1'b1, "R11 set at match", pin_out[0], 1);
        wait_cnt(8'h10);
        check(pin_out[0] == 1'b0, "R11 toggled at wrap", pin_out[0], 0);

        // R1 wrap
        wait_cnt(8'hFF);
        @(negedge clk);
        peek(3'd7, d); check(d == 8'h00, "R1 wrap to zero", d, 0);

        // R6 reset clears state
        bus_write(3'd0, 8'h5C);
        wait_flag(3'd0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        peek(3'd0, d); check(d == 8'h00, "R6 reset clears ctrl0", d, 0);
        check(irq == 2'b00 && pin_oe == 2'b00 && pin_out == 2'b00, "R6 reset clears outputs",
              {irq, pin_oe, pin_out}, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule